// File: doc/BRIEF.md
# Flash Command Sequence Controller

This controller sits between a captured bus-write/read interface and a byte-wide flash array split into four sectors. It recognises a four-write command sequence. The first three writes are fixed unlock writes, and the third carries a one-hot command byte. The fourth write supplies the operand address and data, which the controller latches. It then enters a busy command mode that lasts for a fixed, per-command number of clock cycles. When that time has passed it drops back to normal read mode without being told.

While the controller is busy, the read data port returns one of three things: a status byte, an identification code or, for the verify commands, the array data. Verify data is marked valid only after a settling delay. Program and erase commands give a one-cycle request to the array, with the latched operand. The controller keeps a sticky error flag. The flag is set by a bad unlock or command byte, by a write that comes too long after the one before it, or by a supply drop while a command is running. Only the reset command clears it.

All time limits are given in microseconds and turned into cycle counts from the `CLK_HZ` parameter.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is idle. `busy_o` is 0, `rd_valid_o` is 1, `rd_data_o` follows `arr_rdata_i`, the error flag is clear, and the next write is taken as the first unlock write.
- R2: The sequence 5555h/AAh, 2AAAh/55h, 5555h/command byte, then any operand write, sets `busy_o` on the clock edge that takes the operand write. For every command except erase, `busy_o` then stays high for exactly `TO_US` microseconds' worth of cycles.
- R3: Command byte 80h (erase) keeps `busy_o` high for exactly `ERASE_US` worth of cycles. It pulses `arr_erase_o` for one cycle, together with the busy rise, and `op_addr_o` carries the operand address, whose bits 16:15 select the sector.
- R4: Command byte 40h (program) pulses `arr_prog_o` for one cycle, together with the busy rise. `op_addr_o` and `op_data_o` hold the operand address and data.
- R5: While busy under commands 00h (reset), 01h (status), 10h (converge), 40h (program) or 80h (erase), `rd_data_o` is the status byte. In that byte bit 7 is busy, bit 0 is the error flag, and all other bits are 0.
- R6: While busy under command 02h (identification), `rd_data_o` is 52h when operand address bit 0 is 0, and `DEV_CODE` (default 04h) when it is 1.
- R7: While busy under command 04h or 08h (the two verify commands), `rd_data_o` follows `arr_rdata_i`. `rd_valid_o` is 0 until `VFY_US` worth of cycles have passed since the operand write, and 1 from then on. When idle, `rd_valid_o` is always 1.
- R8: If the first or second write, or the address of the third write, does not match the unlock values, the error flag is set, no command starts, and the next write is taken as the first unlock write.
- R9: A command byte with more than one bit set, or with bit 5 set, sets the error flag and starts no command.
- R10: Once the sequence has begun, a write that comes more than `GAP_US` worth of cycles after the previous write sets the error flag and starts no command. A gap of exactly `GAP_US` worth of cycles is accepted.
- R11: If `low_vcc_i` is high in a busy cycle, the error flag is set and `busy_o` falls at the next clock edge.
- R12: The error flag stays set through later commands. The reset command (00h) clears it on its operand write.
- R13: Writes that arrive while the controller is busy are ignored. They do not change the operand outputs, the busy length, the error flag or the sequence position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One-cycle strobe for a captured bus write |
| wr_addr_i | input | 17 | Address of the captured bus write |
| wr_data_i | input | 8 | Data of the captured bus write |
| low_vcc_i | input | 1 | Supply below lockout |
| arr_rdata_i | input | 8 | Array data at the current bus read address |
| rd_data_o | output | 8 | Byte returned to a bus read |
| rd_valid_o | output | 1 | The read byte is valid |
| busy_o | output | 1 | Command mode is active |
| arr_prog_o | output | 1 | One-cycle program request to the array |
| arr_erase_o | output | 1 | One-cycle sector erase request to the array |
| op_addr_o | output | 17 | Latched operand address |
| op_data_o | output | 8 | Latched operand data |

## Verification
The bench builds the controller with `CLK_HZ` set to 1 MHz, so one cycle is one microsecond. The command timeout is then 250 cycles, the erase timeout 1000 cycles, the write gap limit 150 cycles and the verify settling delay 25 cycles. At these sizes every busy window can be counted cycle by cycle, including the full erase window. The gap limit can be tested on both sides of its boundary, at a gap of 150 cycles and at 151. The verify valid edge can be sampled on the cycle before it and on the cycle it appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [7:0] {
    CMD_RESET    = 8'h00,
    CMD_STATUS   = 8'h01,
    CMD_IDREAD   = 8'h02,
    CMD_VFY0     = 8'h04,
    CMD_VFY1     = 8'h08,
    CMD_CONVERGE = 8'h10,
    CMD_PROGRAM  = 8'h40,
    CMD_ERASE    = 8'h80
  } cmd_e;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLOCK_DATA_A = 8'hAA;
  localparam logic [7:0]  UNLOCK_DATA_B = 8'h55;
  localparam int unsigned STAT_BUSY_BIT = 7;
  localparam int unsigned STAT_ERR_BIT  = 0;

  // bit 5 carries no command
  function automatic logic code_legal(input logic [7:0] c);
    return ($countones(c) <= 1) && !c[5];
  endfunction
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned GAP_CYC = 150
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              start_o,
  output logic [7:0]        code_o,
  output logic              err_o
);
  localparam int unsigned GW = $clog2(GAP_CYC + 2);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYC);
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_CYC + 1);
  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

  logic [1:0]    pos_q;
  logic [GW-1:0] gap_q;
  logic [7:0]    code_q;
  logic          wr, late, step_ok;

  assign wr   = wr_valid_i && en_i;
  // gap_q holds the cycle distance to the previous accepted write
  assign late = (pos_q != 2'd0) && (gap_q > GAP_LIM);

  always_comb begin
    unique case (pos_q)
      2'd0:    step_ok = (wr_addr_i == ADDR_A) && (wr_data_i == UNLOCK_DATA_A);
      2'd1:    step_ok = (wr_addr_i == ADDR_B) && (wr_data_i == UNLOCK_DATA_B);
      2'd2:    step_ok = (wr_addr_i == ADDR_A) && code_legal(wr_data_i);
      default: step_ok = 1'b1;
    endcase
  end

  assign err_o   = wr && (late || !step_ok);
  assign start_o = wr && !late && (pos_q == 2'd3);
  assign code_o  = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= 2'd0;
      gap_q  <= GAP_SAT;
      code_q <= 8'h00;
    end else begin
      if (wr) begin
        pos_q <= err_o ? 2'd0 : pos_q + 2'd1;
        gap_q <= GW'(1);
        if (pos_q == 2'd2) code_q <= wr_data_i;
      end else if (gap_q != GAP_SAT) begin
        gap_q <= gap_q + GW'(1);
      end
    end
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned TO_CYC    = 250,
  parameter int unsigned ERASE_CYC = 1000,
  parameter int unsigned VFY_CYC   = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  input  logic abort_i,
  output logic busy_o,
  output logic vfy_ok_o
);
  localparam int unsigned MAX_CYC = (ERASE_CYC > TO_CYC) ? ERASE_CYC : TO_CYC;
  localparam int unsigned W = $clog2(MAX_CYC + 1);
  localparam logic [W-1:0] SHORT_END = W'(TO_CYC - 1);
  localparam logic [W-1:0] LONG_END  = W'(ERASE_CYC - 1);
  localparam logic [W-1:0] VFY_W     = W'(VFY_CYC);

  logic [W-1:0] elapsed_q, end_q;
  logic         busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      elapsed_q <= '0;
      end_q     <= SHORT_END;
    end else if (start_i) begin
      busy_q    <= 1'b1;
      elapsed_q <= '0;
      end_q     <= long_i ? LONG_END : SHORT_END;
    end else if (busy_q) begin
      if (abort_i || elapsed_q == end_q) busy_q <= 1'b0;
      else elapsed_q <= elapsed_q + W'(1);
    end
  end

  assign busy_o   = busy_q;
  assign vfy_ok_o = elapsed_q >= VFY_W;
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h52,
  parameter logic [7:0] DEV_CODE = 8'h04
) (
  input  logic       busy_i,
  input  cmd_e       cmd_i,
  input  logic       id_sel_i,
  input  logic       err_i,
  input  logic       vfy_ok_i,
  input  logic [7:0] arr_rdata_i,
  output logic [7:0] rd_data_o,
  output logic       rd_valid_o
);
  logic [7:0] status;

  always_comb begin
    status = '0;
    status[STAT_BUSY_BIT] = busy_i;
    status[STAT_ERR_BIT]  = err_i;
  end

  always_comb begin
    rd_data_o  = arr_rdata_i;
    rd_valid_o = 1'b1;
    if (busy_i) begin
      unique case (cmd_i)
        CMD_VFY0, CMD_VFY1: rd_valid_o = vfy_ok_i;
        CMD_IDREAD:         rd_data_o  = id_sel_i ? DEV_CODE : MFR_CODE;
        default:            rd_data_o  = status;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned GAP_US   = 150,
  parameter int unsigned TO_US    = 250,
  parameter int unsigned ERASE_US = 1000,
  parameter int unsigned VFY_US   = 25,
  parameter logic [7:0]  MFR_CODE = 8'h52,
  parameter logic [7:0]  DEV_CODE = 8'h04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              low_vcc_i,
  input  logic [7:0]        arr_rdata_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              arr_prog_o,
  output logic              arr_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned GAP_CYC    = GAP_US * CYC_PER_US;
  localparam int unsigned TO_CYC     = TO_US * CYC_PER_US;
  localparam int unsigned ERASE_CYC  = ERASE_US * CYC_PER_US;
  localparam int unsigned VFY_CYC    = VFY_US * CYC_PER_US;

  logic              start, seq_err, busy, vfy_ok;
  logic [7:0]        code;
  cmd_e              cmd_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [7:0]        op_data_q;
  logic              err_q, prog_q, erase_q;

  flash_seq_decoder #(.ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC)) u_dec (
    .clk_i, .rst_ni,
    .en_i      (!busy),
    .wr_valid_i, .wr_addr_i, .wr_data_i,
    .start_o   (start),
    .code_o    (code),
    .err_o     (seq_err)
  );

  flash_op_timer #(.TO_CYC(TO_CYC), .ERASE_CYC(ERASE_CYC), .VFY_CYC(VFY_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .start_i  (start),
    .long_i   (code == CMD_ERASE),
    .abort_i  (low_vcc_i),
    .busy_o   (busy),
    .vfy_ok_o (vfy_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_RESET;
      op_addr_q <= '0;
      op_data_q <= '0;
      err_q     <= 1'b0;
      prog_q    <= 1'b0;
      erase_q   <= 1'b0;
    end else begin
      prog_q  <= start && (code == CMD_PROGRAM);
      erase_q <= start && (code == CMD_ERASE);
      if (start) begin
        cmd_q     <= cmd_e'(code);
        op_addr_q <= wr_addr_i;
        op_data_q <= wr_data_i;
      end
      if (seq_err || (busy && low_vcc_i)) err_q <= 1'b1;
      else if (start && code == CMD_RESET) err_q <= 1'b0;
    end
  end

  flash_rd_mux #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
    .busy_i      (busy),
    .cmd_i       (cmd_q),
    .id_sel_i    (op_addr_q[0]),
    .err_i       (err_q),
    .vfy_ok_i    (vfy_ok),
    .arr_rdata_i,
    .rd_data_o,
    .rd_valid_o
  );

  assign busy_o      = busy;
  assign arr_prog_o  = prog_q;
  assign arr_erase_o = erase_q;
  assign op_addr_o   = op_addr_q;
  assign op_data_o   = op_data_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              low_vcc_i,
  input logic [7:0]        arr_rdata_i,
  input logic [7:0]        rd_data_o,
  input logic              rd_valid_o,
  input logic              busy_o,
  input logic              arr_prog_o,
  input logic              arr_erase_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic [7:0]        op_data_o
);
  a_r1_idle_array_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_valid_o && rd_data_o == arr_rdata_i));

  a_r2_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_valid_i));

  a_r4_prog_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_prog_o |=> !arr_prog_o);

  a_r3_erase_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_erase_o |=> !arr_erase_o);

  a_r4_req_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_prog_o || arr_erase_o) |-> (busy_o && !(arr_prog_o && arr_erase_o)));

  a_r11_low_vcc_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && low_vcc_i) |=> !busy_o);

  a_r13_operand_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(op_addr_o) && $stable(op_data_o)));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int TO  = 250;
  localparam int ER  = 1000;
  localparam int GAP = 150;
  localparam int VFY = 25;
  localparam logic [16:0] A1 = 17'h05555, A2 = 17'h02AAA;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, low_vcc_i = 1'b0;
  logic [16:0] wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0, arr_rdata_i = 8'h3C;
  logic [7:0]  rd_data_o, op_data_o;
  logic        rd_valid_o, busy_o, arr_prog_o, arr_erase_o;
  logic [16:0] op_addr_o;
  int          vectors = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.CLK_HZ(1_000_000)) u_dut (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_addr_i, .wr_data_i, .low_vcc_i,
    .arr_rdata_i, .rd_data_o, .rd_valid_o, .busy_o, .arr_prog_o,
    .arr_erase_o, .op_addr_o, .op_data_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic b, input logic e);
    return {b, 6'b0, e};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] c, input logic [16:0] a,
                                          input logic e, input logic [7:0] arr);
    case (c)
      8'h02:        return a[0] ? 8'h04 : 8'h52;
      8'h04, 8'h08: return arr;
      default:      return stat(1'b1, e);
    endcase
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c, input logic [16:0] a, input logic [7:0] d);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, c); wr(a, d);
  endtask

  // called at the negedge right after the operand write, minus `spent` cycles
  task automatic run_out(input string req, input int len, input int spent);
    wait_n(len - 1 - spent);
    chk(req, busy_o, 1'b1);
    wait_n(1);
    chk(req, busy_o, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(1);
    chk("R1 busy", busy_o, 0);
    chk("R1 rd", rd_data_o, 8'h3C);
    chk("R1 valid", rd_valid_o, 1);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R1 err clear", rd_data_o, stat(1, 0));
    run_out("R2 status length", TO, 0);

    cmd(8'h40, 17'h1ABCD, 8'h5A);
    chk("R4 prog pulse", arr_prog_o, 1);
    chk("R4 op addr", op_addr_o, 17'h1ABCD);
    chk("R4 op data", op_data_o, 8'h5A);
    chk("R5 prog status", rd_data_o, stat(1, 0));
    wait_n(1);
    chk("R4 pulse end", arr_prog_o, 0);
    cmd(8'h80, 17'h00123, 8'hFF);
    chk("R13 op addr kept", op_addr_o, 17'h1ABCD);
    chk("R13 no erase", arr_erase_o, 0);
    run_out("R13 busy length", TO, 5);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R13 no err", rd_data_o, stat(1, 0));
    run_out("R2", TO, 0);

    cmd(8'h80, 17'h10000, 8'hFF);
    chk("R3 erase pulse", arr_erase_o, 1);
    chk("R3 sector", op_addr_o[16:15], 2'd2);
    run_out("R3 erase length", ER, 0);

    cmd(8'h02, 17'h0, 8'h0);
    chk("R6 mfr", rd_data_o, 8'h52);
    run_out("R6", TO, 0);
    cmd(8'h02, 17'h1, 8'h0);
    chk("R6 dev", rd_data_o, 8'h04);
    run_out("R6", TO, 0);

    arr_rdata_i = 8'hA5;
    cmd(8'h08, 17'h0777, 8'h0);
    wait_n(VFY - 1);
    chk("R7 not yet valid", rd_valid_o, 0);
    wait_n(1);
    chk("R7 valid", rd_valid_o, 1);
    chk("R7 data", rd_data_o, 8'hA5);
    run_out("R7", TO, VFY);

    wr(A1, 8'hAA); wr(A2, 8'h54);
    chk("R8 no busy", busy_o, 0);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R8 err set", rd_data_o, stat(1, 1));
    run_out("R8", TO, 0);
    cmd(8'h10, 17'h00042, 8'h00);
    chk("R12 sticky", rd_data_o, stat(1, 1));
    run_out("R12", TO, 0);
    cmd(8'h00, 17'h0, 8'h0);
    chk("R12 cleared", rd_data_o, stat(1, 0));
    run_out("R12", TO, 0);

    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h03);
    chk("R9 two bits", busy_o, 0);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R9 err", rd_data_o, stat(1, 1));
    run_out("R9", TO, 0);
    cmd(8'h00, 17'h0, 8'h0); run_out("R12", TO, 0);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, 8'h20);
    chk("R9 bit5", busy_o, 0);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R9 bit5 err", rd_data_o, stat(1, 1));
    run_out("R9", TO, 0);
    cmd(8'h00, 17'h0, 8'h0); run_out("R12", TO, 0);

    wr(A1, 8'hAA); wait_n(GAP - 1); wr(A2, 8'h55); wr(A1, 8'h01); wr(17'h0, 8'h0);
    chk("R10 edge gap ok", rd_data_o, stat(1, 0));
    run_out("R10", TO, 0);
    wr(A1, 8'hAA); wait_n(GAP); wr(A2, 8'h55);
    chk("R10 late", busy_o, 0);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R10 err", rd_data_o, stat(1, 1));
    run_out("R10", TO, 0);
    cmd(8'h00, 17'h0, 8'h0); run_out("R12", TO, 0);

    cmd(8'h40, 17'h00010, 8'h11);
    wait_n(10);
    low_vcc_i = 1'b1;
    wait_n(1);
    low_vcc_i = 1'b0;
    chk("R11 abort", busy_o, 0);
    cmd(8'h01, 17'h0, 8'h0);
    chk("R11 err", rd_data_o, stat(1, 1));
    run_out("R11", TO, 0);
    cmd(8'h00, 17'h0, 8'h0); run_out("R12", TO, 0);

    begin
      logic [7:0] codes [7] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h40};
      logic exp_err = 1'b0;
      for (int i = 0; i < 14; i++) begin
        logic [7:0]  c = codes[$urandom_range(6)];
        logic [16:0] a = 17'($urandom);
        logic [7:0]  d = 8'($urandom);
        int          bad = $urandom_range(7);
        arr_rdata_i = 8'($urandom);
        if (bad == 0) begin
          wr(A1, 8'hAB);
          exp_err = 1'b1;
          chk("R8 rand", busy_o, 0);
        end else if (bad == 1) begin
          wr(A1, 8'hAA); wr(A1, 8'h55);
          exp_err = 1'b1;
          chk("R8 rand", busy_o, 0);
        end else begin
          cmd(c, a, d);
          if (c == 8'h00) exp_err = 1'b0;
          chk("R5 R6 R7 rand read", rd_data_o, exp_read(c, a, exp_err, arr_rdata_i));
          chk("R7 rand valid", rd_valid_o, (c == 8'h04 || c == 8'h08) ? 1'b0 : 1'b1);
          chk("R4 rand pulse", arr_prog_o, c == 8'h40);
          run_out("R2 rand", TO, 0);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule